// File: doc/BRIEF.md
# Byte/Word Load-Store Data Aligner

This block sits between a 32-bit register file and a byte-addressable memory with a 32-bit data bus. It is purely combinational and holds no state. Each access is described by an address, a transfer size (one byte or one full word), a direction (load or store) and an external endianness line.

On a load, it turns the memory read word into the value written to the register. A word passes through unchanged. For a byte, the block picks one byte lane, puts it in the low eight bits and clears the rest. On a store, it copies the register's low byte onto every lane for byte writes, or passes the full word through for word writes. It also produces one write enable per byte lane.

The lane that a byte address offset selects depends on the endianness line, which may change from one access to the next. A word access whose address is not a multiple of four raises a fault output, and a faulted store writes nothing.

Top module: `ldst_aligner`

## Requirements
- R1: A word load (isWord=1, isStore=0) returns memRdData unchanged on ldData, whether or not the address is aligned.
- R2: A byte load puts one lane of memRdData into ldData[7:0]. Lane i covers bus bits 8i+7:8i. With bigEndian=0 the lane is i = addr[1:0]; with bigEndian=1 it is i = 3 - addr[1:0].
- R3: After a byte load, ldData[31:8] is zero.
- R4: An aligned word store (addr[1:0]=0) drives stWrData unchanged onto memWrData and sets memByteEn to 4'b1111.
- R5: A byte store drives stWrData[7:0] onto all four lanes of memWrData.
- R6: A byte store sets exactly one bit of memByteEn. With bigEndian=0 that bit is addr[1:0]; with bigEndian=1 it is 3 - addr[1:0]. Enable bit i covers bus bits 8i+7:8i.
- R7: alignFault is 1 exactly when isWord=1 and addr[1:0] is nonzero. A byte access never faults.
- R8: A faulted word store sets memByteEn to 4'b0000.
- R9: A load (isStore=0) sets memByteEn to 4'b0000.
- R10: Address bits above bit 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 32 | Byte address of the access |
| isWord | input | 1 | 1 for a word transfer, 0 for a byte transfer |
| isStore | input | 1 | 1 for a store, 0 for a load |
| bigEndian | input | 1 | External byte-order select; 1 selects big-endian |
| memRdData | input | 32 | Word read from memory |
| stWrData | input | 32 | Register value to be stored |
| ldData | output | 32 | Aligned value returned to the register |
| memWrData | output | 32 | Data bus driven toward memory |
| memByteEn | output | 4 | Per-lane write enables |
| alignFault | output | 1 | Misaligned word access flag |

## Verification
The bench builds the block with its default configuration: 8-bit lanes, four lanes and a 32-bit address. With these values the full control space is small enough to sweep completely. That covers every combination of endianness, size, direction and low address offset. Each combination is run against several data patterns and against high address bits that are zero, mixed and all ones. Every lane mapping, every fault case and the invariance to upper address bits are therefore checked against values the bench computes arithmetically.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  // Number of byte lanes on the memory bus; must be a power of two.
  parameter int unsigned LANE_COUNT = 4;
  localparam int unsigned OFF_W = $clog2(LANE_COUNT);

  // Strobes from control to datapath.
  typedef struct packed {
    logic [LANE_COUNT-1:0] laneSel;   // one-hot byte lane for byte accesses
    logic                  wordMode;  // full-width transfer
    logic                  wrActive;  // store that may write memory
    logic                  fault;     // misaligned word access
  } laneCtl_t;

endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  logic             isWord,
  input  logic             isStore,
  input  logic             bigEndian,
  output laneCtl_t         ctl
);

  logic [OFF_W-1:0] laneIdx;
  logic             misaligned;

  // Reversing lane order equals inverting the offset for a power-of-two lane count.
  assign laneIdx    = bigEndian ? ~offset : offset;
  assign misaligned = isWord && (offset != '0);

  always_comb begin
    ctl          = '0;
    ctl.laneSel  = LANE_COUNT'(1) << laneIdx;
    ctl.wordMode = isWord;
    ctl.fault    = misaligned;
    ctl.wrActive = isStore && !misaligned;
  end

endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANE_COUNT * LANE_W
) (
  input  laneCtl_t              ctl,
  input  logic [DATA_W-1:0]     memRdData,
  input  logic [DATA_W-1:0]     stWrData,
  output logic [DATA_W-1:0]     ldData,
  output logic [DATA_W-1:0]     memWrData,
  output logic [LANE_COUNT-1:0] memByteEn
);

  logic [LANE_W-1:0] laneMasked [LANE_COUNT];
  logic [LANE_W-1:0] pickedByte;

  // Gate each read lane by its select; the OR of all gated lanes is the picked byte.
  for (genvar i = 0; i < LANE_COUNT; i++) begin : g_lane
    assign laneMasked[i] = ctl.laneSel[i] ? memRdData[i*LANE_W +: LANE_W] : '0;
    assign memWrData[i*LANE_W +: LANE_W] =
      ctl.wordMode ? stWrData[i*LANE_W +: LANE_W] : stWrData[LANE_W-1:0];
  end

  always_comb begin
    pickedByte = '0;
    for (int i = 0; i < LANE_COUNT; i++) pickedByte |= laneMasked[i];
  end

  assign ldData = ctl.wordMode ? memRdData
                               : {{(DATA_W-LANE_W){1'b0}}, pickedByte};

  always_comb begin
    if (!ctl.wrActive)    memByteEn = '0;
    else if (ctl.wordMode) memByteEn = '1;
    else                   memByteEn = ctl.laneSel;
  end

endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANE_COUNT * LANE_W
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  isWord,
  input  logic                  isStore,
  input  logic                  bigEndian,
  input  logic [DATA_W-1:0]     memRdData,
  input  logic [DATA_W-1:0]     stWrData,
  output logic [DATA_W-1:0]     ldData,
  output logic [DATA_W-1:0]     memWrData,
  output logic [LANE_COUNT-1:0] memByteEn,
  output logic                  alignFault
);

  laneCtl_t ctl;

  lsa_ctrl ctrl_i (
    .offset    (addr[OFF_W-1:0]),
    .isWord    (isWord),
    .isStore   (isStore),
    .bigEndian (bigEndian),
    .ctl       (ctl)
  );

  lsa_datapath #(.LANE_W(LANE_W)) dp_i (
    .ctl       (ctl),
    .memRdData (memRdData),
    .stWrData  (stWrData),
    .ldData    (ldData),
    .memWrData (memWrData),
    .memByteEn (memByteEn)
  );

  assign alignFault = ctl.fault;

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANE_COUNT * LANE_W
) (
  input logic [ADDR_W-1:0]     addr,
  input logic                  isWord,
  input logic                  isStore,
  input logic                  bigEndian,
  input logic [DATA_W-1:0]     memRdData,
  input logic [DATA_W-1:0]     stWrData,
  input logic [DATA_W-1:0]     ldData,
  input logic [DATA_W-1:0]     memWrData,
  input logic [LANE_COUNT-1:0] memByteEn,
  input logic                  alignFault
);

  always_comb begin
    // R1
    word_load_pass_chk: assert (!(isWord && !isStore) || ldData == memRdData)
      else $error("word load altered read data");
    // R3
    byte_load_zero_chk: assert (isWord || ldData[DATA_W-1:LANE_W] == '0)
      else $error("byte load upper bits not cleared");
    // R6
    byte_store_onehot_chk: assert (!(!isWord && isStore) || $countones(memByteEn) == 1)
      else $error("byte store enables not one-hot");
    // R8
    fault_no_write_chk: assert (!alignFault || memByteEn == '0)
      else $error("faulted access enabled a write");
    // R9
    load_no_write_chk: assert (isStore || memByteEn == '0)
      else $error("load enabled a write");
    // R7
    byte_no_fault_chk: assert (isWord || !alignFault)
      else $error("byte access faulted");
    // R5
    byte_store_repl_chk: assert (isWord || memWrData == {LANE_COUNT{stWrData[LANE_W-1:0]}})
      else $error("byte store lanes not replicated");
  end

endmodule

bind ldst_aligner lsa_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
  .addr       (addr),
  .isWord     (isWord),
  .isStore    (isStore),
  .bigEndian  (bigEndian),
  .memRdData  (memRdData),
  .stWrData   (stWrData),
  .ldData     (ldData),
  .memWrData  (memWrData),
  .memByteEn  (memByteEn),
  .alignFault (alignFault)
);

// File: tb/ldst_aligner_tb_top.sv
module ldst_aligner_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] addr = '0;
  logic        isWord = 1'b0, isStore = 1'b0, bigEndian = 1'b0;
  logic [31:0] memRdData = '0, stWrData = '0;
  logic [31:0] ldData, memWrData;
  logic [3:0]  memByteEn;
  logic        alignFault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ldst_aligner dut_i (
    .addr(addr), .isWord(isWord), .isStore(isStore), .bigEndian(bigEndian),
    .memRdData(memRdData), .stWrData(stWrData), .ldData(ldData),
    .memWrData(memWrData), .memByteEn(memByteEn), .alignFault(alignFault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (addr=%h word=%0b st=%0b be=%0b)",
               req, act, exp, addr, isWord, isStore, bigEndian);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [31:0] hiVals [3];
    logic [31:0] pats   [3];
    hiVals = '{32'h0, 32'h1234_5670, 32'hFFFF_FFFC};
    pats   = '{32'h1122_3344, 32'hA5C3_0F96, 32'hFFFF_00FF};
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #5;
    // idle state (a byte load at address 0): no write, no fault
    chk("R9 idle enables", {28'h0, memByteEn}, 32'h0);
    chk("R7 idle fault", {31'h0, alignFault}, 32'h0);

    for (int be = 0; be < 2; be++)
      for (int w = 0; w < 2; w++)
        for (int st = 0; st < 2; st++)
          for (int off = 0; off < 4; off++)
            for (int h = 0; h < 3; h++)
              for (int p = 0; p < 3; p++) begin
                int lane;
                logic misal;
                @(negedge clk);
                bigEndian = be[0];
                isWord    = w[0];
                isStore   = st[0];
                addr      = hiVals[h] | off;
                memRdData = pats[p];
                stWrData  = ~pats[(p + 1) % 3];
                #5;
                lane  = be ? 3 - off : off;
                misal = (w == 1) && (off != 0);
                // R7 / R10: fault depends only on size and low offset
                chk("R7 R10 alignFault", {31'h0, alignFault}, {31'h0, misal});
                if (st == 0) begin
                  chk("R9 load enables", {28'h0, memByteEn}, 32'h0);
                  if (w == 1) chk("R1 word load", ldData, memRdData);
                  else begin
                    chk("R2 R10 byte lane", {24'h0, ldData[7:0]},
                        (memRdData >> (8 * lane)) & 32'hFF);
                    chk("R3 zero fill", {8'h0, ldData[31:8]}, 32'h0);
                  end
                end else if (w == 1) begin
                  if (misal) chk("R8 faulted store", {28'h0, memByteEn}, 32'h0);
                  else begin
                    chk("R4 word store data", memWrData, stWrData);
                    chk("R4 word store enables", {28'h0, memByteEn}, 32'hF);
                  end
                end else begin
                  chk("R5 byte replicate", memWrData, stWrData[7:0] * 32'h0101_0101);
                  chk("R6 R10 byte enable", {28'h0, memByteEn}, 32'h1 << lane);
                end
              end
    done = 1'b1;
    finishRun();
  end

endmodule